// File: doc/BRIEF.md
# Asymmetric Fault Input Qualifier

This block qualifies a small set of asynchronous, active-high fault inputs for a motor-control PWM stage. Each raw pin is first resynchronized to the system clock. A separate qualifier per pin then decides when a fault is genuine. The qualifier must first see the pin low before it can arm. Once armed, it needs a run of consecutive high samples before it raises the filtered fault level. A single low sample is enough to drop the level again.

The block has two outputs per pin. The filtered level is the live pin status. The event output is a one-clock pulse that fires on each qualified rising edge; a sticky flag kept elsewhere is meant to capture it. Interrupt generation, flag storage and the actual PWM shutdown are the concern of the surrounding logic. With the default parameters the block serves four pins, uses a two-flop synchronizer and requires two high samples.

Top module: `fault_qual_bank`

## Requirements
- R1: A synchronous active-high reset clears every filtered level and every event pulse to 0 and leaves each qualifier disarmed. A pin that is held high through and after reset never raises its level until that pin has first been seen low.
- R2: Each pin passes through a two-stage synchronizer. Take an armed qualifier whose pin is high at two consecutive rising edges, with edge A the first of them. The filtered level is then 1 right after the fourth rising edge counted from A, with A counted as the first.
- R3: A high pin that is seen at only one sampling edge, with low samples on both sides, never raises the filtered level.
- R4: Take an asserted qualifier whose pin is low at edge B, with edge B counted as the first. The filtered level is 0 right after the third rising edge, which needs only that one low sample.
- R5: The event output of a pin is 1 for exactly one clock, in the same cycle in which that pin's filtered level goes from 0 to 1. It stays 0 for as long as the level is then held high.
- R6: The single low sample that ends a fault also re-arms the qualifier. Two further consecutive high samples then raise the level again and produce a new event pulse.
- R7: A low sample in the middle of a high run restarts the count. The pattern high, low, high, high asserts the level only after the last two highs.
- R8: The pins are qualified independently. Activity on one pin never changes the level or the event of another pin.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_raw | input | N_CH (4) | Raw asynchronous fault pins, active high |
| flt_level | output | N_CH (4) | Filtered fault level per pin |
| flt_event | output | N_CH (4) | One-clock pulse on each qualified rising edge per pin |

## Verification
The hardest case to reach from the ports is the boundary between a single-sample high glitch and a genuine two-sample fault. It is hardest when the glitch comes right before a real run, or right after a release, because the arming state and the partial count are both invisible at the outputs. The stimulus drives directed patterns one cycle at a time at exactly those boundaries: 1010 glitch trains, high-low-high-high, and a single low cycle inside a long fault. It also holds the pin high across reset to show that the block stays disarmed. A long independent random toggle phase on all four pins then looks for interactions between channels.

// File: rtl/fltq_pkg.sv
package fltq_pkg;

    // Qualifier states: waiting for a first low, armed and counting, fault held
    typedef enum logic [1:0] {
        QS_WAIT_LOW = 2'd0,
        QS_ARMED    = 2'd1,
        QS_FAULT    = 2'd2
    } qual_state_e;

    // Per-channel result of the qualifier
    typedef struct packed {
        logic level;
        logic evt;
    } qual_out_t;

    // Width of the high-sample counter for a given number of required samples
    function automatic int unsigned cnt_width(input int unsigned samples);
        return (samples > 2) ? $clog2(samples) : 1;
    endfunction

endpackage

// File: rtl/fltq_sync.sv
module fltq_sync #(
    parameter int unsigned WIDTH     = 4,
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= {WIDTH{RESET_VAL}};
                else     stage_q[g] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stage_q[g] <= {WIDTH{RESET_VAL}};
                else     stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/fltq_filter.sv
module fltq_filter
    import fltq_pkg::*;
#(
    parameter int unsigned HIGH_SAMPLES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      smp,
    output qual_out_t q
);

    localparam int unsigned CNT_W = cnt_width(HIGH_SAMPLES);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(HIGH_SAMPLES - 1);

    qual_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             level_q, evt_q, evt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        evt_d   = 1'b0;
        unique case (state_q)
            QS_WAIT_LOW: begin
                cnt_d = '0;
                if (!smp) state_d = QS_ARMED;
            end
            QS_ARMED: begin
                if (!smp) begin
                    cnt_d = '0;
                end else if (cnt_q == LAST_CNT) begin
                    state_d = QS_FAULT;
                    cnt_d   = '0;
                    evt_d   = 1'b1;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            QS_FAULT: begin
                cnt_d = '0;
                if (!smp) state_d = QS_ARMED;
            end
            default: begin
                state_d = QS_WAIT_LOW;
                cnt_d   = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= QS_WAIT_LOW;
            cnt_q   <= '0;
            level_q <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            level_q <= (state_d == QS_FAULT);
            evt_q   <= evt_d;
        end
    end

    assign q.level = level_q;
    assign q.evt   = evt_q;

    AST_EVT_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        evt_q |-> (level_q && !$past(level_q)));                            // R5
    AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        evt_q |=> !evt_q);                                                   // R5
    AST_RISE_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(level_q) |-> ($past(smp) && $past(cnt_q) == LAST_CNT));       // R3
    AST_FALL_ON_LOW: assert property (@(posedge clk) disable iff (rst)
        (level_q && !smp) |=> !level_q);                                     // R4
    AST_NO_RISE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (state_q == QS_WAIT_LOW) |=> !level_q);                              // R1

endmodule

// File: rtl/fault_qual_bank.sv
module fault_qual_bank
    import fltq_pkg::*;
#(
    parameter int unsigned N_CH         = 4,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned HIGH_SAMPLES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_CH-1:0] pin_raw,
    output logic [N_CH-1:0] flt_level,
    output logic [N_CH-1:0] flt_event
);

    logic [N_CH-1:0] pin_sync;
    qual_out_t       ch_out [N_CH];

    // Synchronizer resets to the high level so reset itself never arms a channel
    fltq_sync #(
        .WIDTH     (N_CH),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pin_raw),
        .dout (pin_sync)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        fltq_filter #(
            .HIGH_SAMPLES (HIGH_SAMPLES)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .smp (pin_sync[c]),
            .q   (ch_out[c])
        );
        assign flt_level[c] = ch_out[c].level;
        assign flt_event[c] = ch_out[c].evt;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (flt_level == '0 && flt_event == '0));                      // R1
    AST_EVT_IMPLIES_LEVEL: assert property (@(posedge clk) disable iff (rst)
        ((flt_event & ~flt_level) == '0));                                   // R5

endmodule

// File: tb/tb_fault_qual_bank.sv
module tb_fault_qual_bank;

    localparam int NCH = 4;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] pin_raw = '1;
    logic [NCH-1:0] flt_level, flt_event;

    fault_qual_bank #(.N_CH(NCH), .SYNC_STAGES(2), .HIGH_SAMPLES(2)) dut (
        .clk       (clk),
        .rst       (rst),
        .pin_raw   (pin_raw),
        .flt_level (flt_level),
        .flt_event (flt_event)
    );

    always #5 clk = ~clk;

    int    vectors  = 0;
    int    failures = 0;
    int    cycles   = 0;
    bit    started  = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // Behavioural reference: delay line, arming flag, high-run counter
    bit d0 [NCH];
    bit d1 [NCH];
    bit armed [NCH];
    int run [NCH];
    bit m_lvl [NCH];
    bit m_evt [NCH];

    always @(posedge clk) begin
        started = 1;
        for (int c = 0; c < NCH; c++) begin
            if (rst) begin
                d0[c] = 1; d1[c] = 1; armed[c] = 0; run[c] = 0;
                m_lvl[c] = 0; m_evt[c] = 0;
            end else begin
                bit s;
                s = d1[c];
                d1[c] = d0[c];
                d0[c] = pin_raw[c];
                m_evt[c] = 0;
                if (!armed[c]) begin
                    if (!s) armed[c] = 1;
                end else if (m_lvl[c]) begin
                    if (!s) m_lvl[c] = 0;
                end else if (s) begin
                    run[c] = run[c] + 1;
                    if (run[c] >= 2) begin
                        m_lvl[c] = 1; m_evt[c] = 1; run[c] = 0;
                    end
                end else begin
                    run[c] = 0;
                end
            end
        end
    end

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            for (int c = 0; c < NCH; c++) begin
                vectors++;
                if (flt_level[c] !== m_lvl[c] || flt_event[c] !== m_evt[c]) begin
                    failures++;
                    $display("FAIL %s ch%0d cycle %0d: level/event actual %b%b expected %b%b",
                             cur_req, c, cycles, flt_level[c], flt_event[c], m_lvl[c], m_evt[c]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog: actual cycles %0d expected below 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
            $finish;
        end
    end

    task automatic put(input logic [NCH-1:0] v, input int n, input string tag);
        cur_req = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pin_raw = v;
        end
    endtask

    task automatic seq_all(input string pat, input string tag);
        for (int i = 0; i < pat.len(); i++)
            put((pat[i] == "1") ? '1 : '0, 1, tag);
    endtask

    initial begin
        // R1: reset with pins high, then stay high: must remain disarmed
        put('1, 4, "R1");
        @(negedge clk); rst = 0;
        put('1, 12, "R1");
        // R2 / R5: arm with a low, then a long fault held
        put('0, 3, "R2");
        put('1, 10, "R5");
        // R4 / R6: one low cycle releases, two highs re-assert
        put('0, 1, "R4");
        put('1, 6, "R6");
        put('0, 4, "R4");
        // R3: isolated single-sample highs
        seq_all("1010101010100000", "R3");
        // R7: high, low, high, high
        seq_all("10110000", "R7");
        seq_all("1001100111000", "R7");
        // R8: one channel at a time
        for (int c = 0; c < NCH; c++) begin
            put(NCH'(1) << c, 6, "R8");
            put('0, 3, "R8");
        end
        put(4'b0101, 5, "R8");
        put(4'b1010, 5, "R8");
        // R1: reset in the middle of a fault
        put('1, 5, "R1");
        @(negedge clk); rst = 1;
        put('1, 3, "R1");
        @(negedge clk); rst = 0;
        put('1, 6, "R1");
        put('0, 2, "R2");
        // R8: independent random toggling per channel
        cur_req = "R8";
        for (int i = 0; i < 3000; i++) begin
            logic [NCH-1:0] flip;
            for (int c = 0; c < NCH; c++)
                flip[c] = ($urandom_range(0, 3) == 0);
            @(negedge clk);
            pin_raw = pin_raw ^ flip;
        end
        put('0, 6, "R4");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, failures);
        $finish;
    end

endmodule